// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

This block lets software choose which general-purpose pad drives each of a set of interrupt lines. A table of slots, packed four per 32-bit configuration word, gives every interrupt line an enable flag and a 7-bit pad number. While a slot is enabled and its pad number names an existing pad, the line carries that pad's level after a two-flop synchronizer. Otherwise the line is held low.

Each line also has a rising-edge detector. A detected rise sets a sticky pending bit, and software reads these bits from a status word. Writing a 1 to a bit of that word clears the bit. Turning a slot off wipes its pending bit as well. A single pad may feed any number of lines at once, and each of those lines behaves on its own.

With the default parameters there are 80 pads, eight configuration words and 32 lines. Address 0 to 7 select the configuration words and address 8 selects the status word.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every configuration word and the status word read as zero, and all interrupt lines are low.
- R2: A write to address 0 to 7 stores all 32 data bits, and reading the same address returns them unchanged.
- R3: Line k is controlled by configuration word k/4, byte k%4, where byte 0 is bits 7:0. Within that byte, bit 7 is the enable and bits 6:0 are the pad number.
- R4: While a slot is enabled with a pad number below 80, its line equals that pad as sampled two clock edges earlier. A pad change shows up on the line after exactly two rising edges.
- R5: A slot whose enable bit is 0 holds its line low whatever the pads do, and it never sets its pending bit.
- R6: An enabled slot whose pad number is 80 to 127 holds its line low and never sets its pending bit.
- R7: A rising edge on an enabled line sets the line's bit in the status word (address 8, bit k for line k). The bit becomes visible on the third rising clock edge after the pad rises, and it stays set after the pad falls.
- R8: Writing the status word clears exactly the pending bits written as 1 and leaves the others alone. A new edge in the same cycle wins over the clear.
- R9: When a slot is disabled, its pending bit reads zero from the clock edge after the disabling write.
- R10: Several enabled slots may name the same pad. Each of their lines follows the pad, and each pending bit is set and cleared independently.
- R11: Writes to addresses 9 to 15 change no configuration word and no pending bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Register address for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| padIn | input | NUM_PADS (80) | Pad levels |
| irqOut | output | 4*NUM_REGS (32) | Routed, synchronized interrupt lines |

## Verification
A slot table decoded from the wrong byte or bit shows up two edges after a pad change: a different line rises, or the expected line stays low. A synchronizer or edge flop holding a stale value shows up either as a wrong line level after two edges or as a pending bit that appears on a cycle other than the third. A pending bit that is stuck, or that ignores a clear or a disable, shows in the status word on the first read after the clearing write or after the next edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  parameter int SLOTS_PER_REG = 4;
  parameter int SLOT_W        = 8;
  parameter int IDX_W         = 7;
  parameter int DATA_W        = 32;

  // strobes issued by the register control to the line datapath
  typedef struct packed {
    logic clrValid;   // a write to the status word is happening this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_REGS   = 8,
  parameter int NUM_LINES  = NUM_REGS * SLOTS_PER_REG,
  parameter int STAT_WORDS = (NUM_LINES + DATA_W - 1) / DATA_W,
  parameter int ADDR_W     = $clog2(NUM_REGS + STAT_WORDS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wrData,
  output logic [DATA_W-1:0]                rdData,
  input  logic [NUM_LINES-1:0]             pending,
  output logic [NUM_LINES-1:0]             slotEn,
  output logic [NUM_LINES-1:0][IDX_W-1:0]  slotIdx,
  output ctrlStrobe_t                      strb,
  output logic [NUM_LINES-1:0]             clrMask
);
  localparam int PEND_W = STAT_WORDS * DATA_W;

  logic [DATA_W-1:0] cfgReg [NUM_REGS];
  logic [PEND_W-1:0] pendPad;
  logic              statHit;

  // configuration word storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) cfgReg[r] <= '0;
    end else if (wrEn) begin
      for (int r = 0; r < NUM_REGS; r++)
        if (addr == ADDR_W'(r)) cfgReg[r] <= wrData;
    end
  end

  // slot decode: line k lives in word k/4, byte k%4
  for (genvar k = 0; k < NUM_LINES; k++) begin : gSlot
    localparam int REG_I = k / SLOTS_PER_REG;
    localparam int BYTE0 = (k % SLOTS_PER_REG) * SLOT_W;
    assign slotEn[k]  = cfgReg[REG_I][BYTE0 + SLOT_W - 1];
    assign slotIdx[k] = cfgReg[REG_I][BYTE0 +: IDX_W];
    assign clrMask[k] = (addr == ADDR_W'(NUM_REGS + k / DATA_W)) && wrData[k % DATA_W];
  end

  // status-word write detection
  always_comb begin
    statHit = 1'b0;
    for (int w = 0; w < STAT_WORDS; w++)
      if (addr == ADDR_W'(NUM_REGS + w)) statHit = 1'b1;
    strb.clrValid = wrEn && statHit;
  end

  // read mux
  always_comb begin
    pendPad = '0;
    pendPad[NUM_LINES-1:0] = pending;
    rdData = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (addr == ADDR_W'(r)) rdData = cfgReg[r];
    for (int w = 0; w < STAT_WORDS; w++)
      if (addr == ADDR_W'(NUM_REGS + w)) rdData = pendPad[w*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS  = 80,
  parameter int NUM_LINES = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [NUM_PADS-1:0]              padIn,
  input  logic [NUM_LINES-1:0]             slotEn,
  input  logic [NUM_LINES-1:0][IDX_W-1:0]  slotIdx,
  input  ctrlStrobe_t                      strb,
  input  logic [NUM_LINES-1:0]             clrMask,
  output logic [NUM_LINES-1:0]             irqOut,
  output logic [NUM_LINES-1:0]             pending
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : gLine
    logic routed;
    logic syncA, syncB, lastB, pendQ;
    logic riseSeen, clrHit;

    // select the pad, or force low when disabled or out of range
    always_comb begin
      routed = 1'b0;
      if (slotEn[k] && (int'(slotIdx[k]) < NUM_PADS))
        routed = padIn[slotIdx[k]];
    end

    assign riseSeen = syncB && !lastB;
    assign clrHit   = strb.clrValid && clrMask[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA <= 1'b0;
        syncB <= 1'b0;
        lastB <= 1'b0;
        pendQ <= 1'b0;
      end else begin
        syncA <= routed;
        syncB <= syncA;
        lastB <= syncB;
        if (!slotEn[k])    pendQ <= 1'b0;
        else if (riseSeen) pendQ <= 1'b1;
        else if (clrHit)   pendQ <= 1'b0;
      end
    end

    assign irqOut[k]  = syncB;
    assign pending[k] = pendQ;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter  int NUM_PADS   = 80,
  parameter  int NUM_REGS   = 8,
  localparam int NUM_LINES  = NUM_REGS * SLOTS_PER_REG,
  localparam int STAT_WORDS = (NUM_LINES + DATA_W - 1) / DATA_W,
  localparam int ADDR_W     = $clog2(NUM_REGS + STAT_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_PADS-1:0]  padIn,
  output logic [NUM_LINES-1:0] irqOut
);
  logic [NUM_LINES-1:0]            slotEn;
  logic [NUM_LINES-1:0][IDX_W-1:0] slotIdx;
  logic [NUM_LINES-1:0]            clrMask;
  logic [NUM_LINES-1:0]            pending;
  ctrlStrobe_t                     strb;

  gpio_irq_ctrl #(
    .NUM_REGS(NUM_REGS), .NUM_LINES(NUM_LINES),
    .STAT_WORDS(STAT_WORDS), .ADDR_W(ADDR_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pending(pending), .slotEn(slotEn), .slotIdx(slotIdx),
    .strb(strb), .clrMask(clrMask)
  );

  gpio_irq_dp #(
    .NUM_PADS(NUM_PADS), .NUM_LINES(NUM_LINES)
  ) dp (
    .clk(clk), .rstN(rstN), .padIn(padIn), .slotEn(slotEn), .slotIdx(slotIdx),
    .strb(strb), .clrMask(clrMask), .irqOut(irqOut), .pending(pending)
  );
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PADS  = 80,
  parameter int NUM_LINES = 32
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [NUM_PADS-1:0]             padIn,
  input logic [NUM_LINES-1:0]            irqOut,
  input logic [NUM_LINES-1:0]            slotEn,
  input logic [NUM_LINES-1:0][IDX_W-1:0] slotIdx,
  input ctrlStrobe_t                     strb,
  input logic [NUM_LINES-1:0]            clrMask,
  input logic [NUM_LINES-1:0]            pending
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : gChk
    a_r4_follows_pad: assert property (@(posedge clk) disable iff (!rstN)
      $past(slotEn[k] && (int'(slotIdx[k]) < NUM_PADS), 2)
        |-> irqOut[k] == $past(padIn[slotIdx[k]], 2));

    a_r5_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
      $past(!slotEn[k], 2) |-> !irqOut[k]);

    a_r6_range_low: assert property (@(posedge clk) disable iff (!rstN)
      $past(slotEn[k] && (int'(slotIdx[k]) >= NUM_PADS), 2) |-> !irqOut[k]);

    a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rstN)
      ($past(irqOut[k]) && !$past(irqOut[k], 2) && $past(slotEn[k])) |-> pending[k]);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
      $past(pending[k] && slotEn[k] && !(strb.clrValid && clrMask[k])) |-> pending[k]);

    a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strb.clrValid && clrMask[k]) && !($past(irqOut[k]) && !$past(irqOut[k], 2)))
        |-> !pending[k]);

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
      $past(!slotEn[k]) |-> !pending[k]);
  end
endmodule

bind gpio_irq_router gpio_irq_router_chk #(
  .NUM_PADS(NUM_PADS), .NUM_LINES(NUM_LINES)
) chk (
  .clk(clk), .rstN(rstN), .padIn(padIn), .irqOut(irqOut), .slotEn(slotEn),
  .slotIdx(slotIdx), .strb(strb), .clrMask(clrMask), .pending(pending)
);

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;
  localparam int NP = 80;
  localparam int NL = 32;
  localparam int AW = 4;
  localparam logic [AW-1:0] STAT = 4'd8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [NP-1:0] padIn = '0;
  logic [NL-1:0] irqOut;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  gpio_irq_router uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .irqOut(irqOut)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = AW'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = AW'(a);
    #1 d = rdData;
  endtask

  function automatic logic [31:0] cfgVal(input int line, input bit en, input int idx);
    logic [7:0] b;
    b = {en, 7'(idx)};
    return 32'(b) << (8 * (line % 4));
  endfunction

  function automatic logic [NP-1:0] padBit(input int p);
    return NP'(1) << p;
  endfunction

  task automatic clearCfg();
    for (int r = 0; r < 8; r++) wr(r, 32'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    for (int a = 0; a <= 8; a++) begin
      rd(a, v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 reset lines", irqOut, 32'h0);

    // R2: write and read back every configuration word
    for (int r = 0; r < 8; r++) wr(r, 32'h5A3C0F00 ^ (32'h01010101 * 32'(r + 1)));
    for (int r = 0; r < 8; r++) begin
      rd(r, v);
      chk("R2 readback", v, 32'h5A3C0F00 ^ (32'h01010101 * 32'(r + 1)));
    end

    // R11: unmapped writes change nothing
    for (int a = 9; a < 16; a++) wr(a, 32'hFFFFFFFF);
    for (int r = 0; r < 8; r++) begin
      rd(r, v);
      chk("R11 cfg untouched", v, 32'h5A3C0F00 ^ (32'h01010101 * 32'(r + 1)));
    end
    rd(8, v);
    chk("R11 status untouched", v, 32'h0);
    clearCfg();

    // R3/R4: every line against every pad
    for (int k = 0; k < NL; k++) begin
      for (int p = 0; p < NP; p++) begin
        wr(k / 4, cfgVal(k, 1'b1, p));
        padIn = padBit(p);
        idle(3);
        chk("R3 line map", irqOut, 32'h1 << k);
        padIn = ~padBit(p);
        idle(3);
        chk("R4 other pads ignored", irqOut, 32'h0);
      end
      padIn = '0;
      wr(k / 4, 32'h0);
    end

    // R4: two-edge latency
    wr(1, cfgVal(5, 1'b1, 17));
    padIn = '0;
    idle(3);
    padIn = padBit(17);
    idle(1);
    chk("R4 latency one edge", irqOut, 32'h0);
    idle(1);
    chk("R4 latency two edges", irqOut, 32'h1 << 5);
    padIn = '0;
    wr(1, 32'h0);
    idle(3);

    // R5: disabled slots with valid pad numbers stay low
    for (int r = 0; r < 8; r++)
      wr(r, cfgVal(0, 1'b0, r*4) | cfgVal(1, 1'b0, r*4+1) | cfgVal(2, 1'b0, r*4+2) | cfgVal(3, 1'b0, r*4+3));
    padIn = '1;
    idle(4);
    chk("R5 disabled low", irqOut, 32'h0);
    rd(8, v);
    chk("R5 no pending", v, 32'h0);
    padIn = '0;

    // R6: out-of-range pad numbers stay low
    for (int r = 0; r < 8; r++)
      wr(r, cfgVal(0, 1'b1, 80 + (r*4) % 48) | cfgVal(1, 1'b1, 80 + (r*4+1) % 48) |
            cfgVal(2, 1'b1, 80 + (r*4+2) % 48) | cfgVal(3, 1'b1, 127 - r));
    idle(2);
    padIn = '1;
    idle(4);
    chk("R6 range low", irqOut, 32'h0);
    rd(8, v);
    chk("R6 no pending", v, 32'h0);
    padIn = '0;
    clearCfg();
    idle(3);

    // R7: pending timing and stickiness (line 9 on pad 33)
    wr(8, 32'hFFFFFFFF);
    wr(2, cfgVal(9, 1'b1, 33));
    idle(3);
    padIn = padBit(33);
    idle(2);
    rd(8, v);
    chk("R7 not yet pending", v, 32'h0);
    idle(1);
    rd(8, v);
    chk("R7 pending on third edge", v, 32'h1 << 9);
    padIn = '0;
    idle(4);
    rd(8, v);
    chk("R7 sticky", v, 32'h1 << 9);

    // R8: selective write-one-to-clear (line 20 on pad 2)
    wr(5, cfgVal(20, 1'b1, 2));
    idle(3);
    padIn = padBit(2);
    idle(4);
    padIn = '0;
    idle(3);
    rd(8, v);
    chk("R8 two pending", v, (32'h1 << 9) | (32'h1 << 20));
    wr(8, 32'h1 << 20);
    rd(8, v);
    chk("R8 clear one", v, 32'h1 << 9);
    wr(8, 32'h0);
    rd(8, v);
    chk("R8 zero write keeps", v, 32'h1 << 9);
    wr(8, 32'h1 << 9);
    rd(8, v);
    chk("R8 clear other", v, 32'h0);

    // R9: disable clears pending one edge later
    padIn = padBit(33);
    idle(4);
    padIn = '0;
    idle(2);
    rd(8, v);
    chk("R9 pending before disable", v, 32'h1 << 9);
    wr(2, 32'h0);
    rd(8, v);
    chk("R9 still set at write edge", v, 32'h1 << 9);
    idle(1);
    rd(8, v);
    chk("R9 cleared next edge", v, 32'h0);
    clearCfg();
    idle(3);
    wr(8, 32'hFFFFFFFF);

    // R10: three lines share pad 55
    wr(0, cfgVal(0, 1'b1, 55));
    wr(3, cfgVal(13, 1'b1, 55));
    wr(7, cfgVal(31, 1'b1, 55));
    idle(3);
    padIn = padBit(55);
    idle(4);
    chk("R10 shared pad lines", irqOut, 32'h80002001);
    padIn = '0;
    idle(4);
    rd(8, v);
    chk("R10 shared pad pending", v, 32'h80002001);
    wr(3, 32'h0);
    idle(1);
    rd(8, v);
    chk("R10 independent pending", v, 32'h80000001);
    padIn = padBit(55);
    idle(4);
    chk("R10 independent lines", irqOut, 32'h80000001);
    padIn = '0;
    idle(3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule